// File: doc/BRIEF.md
# Constrained Serial Pattern Recognizer

This block watches a serial bit stream, taking one bit per rising clock edge, and raises a match flag whenever the most recently sampled bits end in the run 0,1,0. A second run, 1,0,0, acts as a veto. The first time it shows up after a reset, the block locks into a dead state. The flag then stays low until the next reset, whatever bits follow.

The block is a Moore machine. The match flag is decoded from the state register alone, so it changes only just after a clock edge and never follows the input within a cycle. A synchronous, active-high reset returns the machine to its idle state. The user drives one data bit per cycle and reads the registered verdict one cycle later.

Top module: `seq_veto_detector`

## Requirements
- R1: On a rising edge with `rst` high, the machine returns to idle, and `z_o` reads 0 in the cycle that follows.
- R2: When the last three bits sampled since reset were 0, 1 and 0 (oldest first), and 1,0,0 has not yet been sampled, `z_o` is 1 in the cycle after the edge that took the final 0.
- R3: Matches may overlap: the stream 0,1,0,1,0 raises `z_o` after the third bit and again after the fifth, with `z_o` at 0 after the fourth.
- R4: Once three consecutive samples since reset read 1, 0 and 0, `z_o` stays at 0 on every later cycle until reset, whatever bits are applied.
- R5: A 0 sampled right after a match (a history ending 0,1,0,0) trips the veto, so `z_o` falls and stays low.
- R6: `z_o` depends only on the state: changing `x_i` between clock edges leaves `z_o` unchanged until the next edge.
- R7: A reset applied after the veto has tripped clears it, and 0,1,0 is recognised again.
- R8: Long runs of equal bits before a pattern do not prevent detection. Both 0,0,0,1,0 and 1,1,1,0,1,0 raise `z_o` after their last bit.
- R9: A history ending 1,0,1 does not trip the veto, so 1,0,1,0 gives a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `x_i` sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_i | input | 1 | Serial data bit |
| z_o | output | 1 | Match flag, Moore output |

## Verification
On every cycle the assertions check four things. A high `z_o` is always preceded by 0,1,0 on the input. Any 1,0,0 seen since reset leaves the machine in the dead state. The dead state never releases without reset and never shows a high flag. A reset always leaves the flag low. The bench scenarios are needed for the rest. They confirm that every qualifying 0,1,0 actually produces a flag, including overlapping matches and matches after long runs. They also confirm that a reset revives detection and that a mid-cycle input change never reaches the output. A reference model with a three-bit history and a sticky veto flag compares every cycle of a random stream with periodic resets.

// File: rtl/seq_veto_pkg.sv
package seq_veto_pkg;

  localparam int STATE_W = 3;

  // Each state names the suffix of the input history that still matters.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,  // nothing sampled since reset
    ST_Z     = 3'd1,  // ends in 0, with no 1 directly before it
    ST_O     = 3'd2,  // ends in 1, not preceded by a lone 0
    ST_ZO    = 3'd3,  // ends in 0,1
    ST_OZ    = 3'd4,  // ends in 1,0 (not a match)
    ST_MATCH = 3'd5,  // ends in 0,1,0
    ST_DEAD  = 3'd6   // 1,0,0 has been sampled; sticky
  } vstate_t;

  function automatic vstate_t step_state(input vstate_t cur, input logic bit_in);
    vstate_t nxt;
    unique case (cur)
      ST_IDLE:  nxt = bit_in ? ST_O  : ST_Z;
      ST_Z:     nxt = bit_in ? ST_ZO : ST_Z;
      ST_O:     nxt = bit_in ? ST_O  : ST_OZ;
      ST_ZO:    nxt = bit_in ? ST_O  : ST_MATCH;
      ST_OZ:    nxt = bit_in ? ST_ZO : ST_DEAD;
      ST_MATCH: nxt = bit_in ? ST_ZO : ST_DEAD;
      ST_DEAD:  nxt = ST_DEAD;
      default:  nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  function automatic logic is_match(input vstate_t cur);
    return cur == ST_MATCH;
  endfunction

endpackage

// File: rtl/seq_veto_next.sv
module seq_veto_next
  import seq_veto_pkg::*;
(
  input  vstate_t cur_state,
  input  logic    bit_in,
  output vstate_t nxt_state,
  output logic    trap_hit
);
  always_comb begin
    nxt_state = step_state(cur_state, bit_in);
    trap_hit  = (nxt_state == ST_DEAD) && (cur_state != ST_DEAD);
  end
endmodule

// File: rtl/seq_veto_reg.sv
module seq_veto_reg
  import seq_veto_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  vstate_t nxt_state,
  output vstate_t cur_state
);
  always_ff @(posedge clk) begin
    if (rst) cur_state <= ST_IDLE;
    else     cur_state <= nxt_state;
  end
endmodule

// File: rtl/seq_veto_out.sv
module seq_veto_out
  import seq_veto_pkg::*;
(
  input  vstate_t cur_state,
  output logic    match_o,
  output logic    dead_o
);
  always_comb begin
    match_o = is_match(cur_state);
    dead_o  = (cur_state == ST_DEAD);
  end
endmodule

// File: rtl/seq_veto_detector.sv
module seq_veto_detector
  import seq_veto_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x_i,
  output logic z_o
);
  vstate_t state_q;
  vstate_t state_d;
  logic    enter_trap;
  logic    in_trap;
  logic    match_now;

  seq_veto_next u_next (
    .cur_state (state_q),
    .bit_in    (x_i),
    .nxt_state (state_d),
    .trap_hit  (enter_trap)
  );

  seq_veto_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (state_d),
    .cur_state (state_q)
  );

  seq_veto_out u_out (
    .cur_state (state_q),
    .match_o   (match_now),
    .dead_o    (in_trap)
  );

  assign z_o = match_now;
endmodule

// File: rtl/seq_veto_chk.sv
module seq_veto_chk (
  input logic clk,
  input logic rst,
  input logic x_i,
  input logic z_o,
  input logic in_trap,
  input logic enter_trap
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !z_o);

  // R2
  match_has_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    z_o |-> (since_rst == 2'd3 && !$past(x_i, 1) && $past(x_i, 2) && !$past(x_i, 3)));

  // R4
  veto_pattern_traps_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && !$past(x_i, 1) && !$past(x_i, 2) && $past(x_i, 3)) |-> in_trap);

  // R4
  trap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    in_trap |=> in_trap);

  // R4
  trap_silent_chk: assert property (@(posedge clk) disable iff (rst)
    in_trap |-> !z_o);

  // R5
  trap_entry_chk: assert property (@(posedge clk) disable iff (rst)
    enter_trap |=> (in_trap && !z_o));
endmodule

bind seq_veto_detector seq_veto_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .x_i        (x_i),
  .z_o        (z_o),
  .in_trap    (in_trap),
  .enter_trap (enter_trap)
);

// File: tb/seq_veto_detector_tb.sv
`timescale 1ns/1ps
module seq_veto_detector_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_i = 1'b0;
  logic z_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [2:0] hist = 3'b000;
  int         cnt  = 0;
  bit         seen = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  seq_veto_detector u_dut (.clk(clk), .rst(rst), .x_i(x_i), .z_o(z_o));

  function automatic logic want_z(input logic [2:0] h, input int c, input bit vetoed);
    return !vetoed && c >= 3 && h == 3'b010;
  endfunction

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (z_o !== exp) begin
      n_fail++;
      $display("FAIL %s: z_o=%b expected %b at %0t", req, z_o, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    hist = 3'b000; cnt = 0; seen = 1'b0;
    #1 rst = 1'b0;
  endtask

  // Apply one bit, update the model on the edge, compare just after it.
  task automatic step(input logic b, input string req);
    x_i = b;
    @(posedge clk);
    hist = {hist[1:0], b};
    if (cnt < 3) cnt++;
    if (cnt >= 3 && hist == 3'b100) seen = 1'b1;
    #1 check(req, want_z(hist, cnt, seen));
  endtask

  task automatic seq(input logic [15:0] bits, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) step(bits[i], req);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic hold;
    void'($urandom(32'h5eed_1234));
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 reset state", 1'b0);

    // R2: basic match
    seq(16'b010, 3, "R2");
    check("R2 direct", 1'b1);

    // R6: mid-cycle input change does not reach z_o
    hold = z_o;
    #1 x_i = ~x_i;
    #1 check("R6 mid-cycle", hold);
    x_i = ~x_i;

    // R3: overlapping matches 0,1,0,1,0
    do_reset();
    step(0, "R3"); step(1, "R3"); step(0, "R3");
    check("R3 first", 1'b1);
    step(1, "R3"); check("R3 gap", 1'b0);
    step(0, "R3"); check("R3 second", 1'b1);

    // R5: 0 right after a match trips the veto
    step(0, "R5"); check("R5 trap", 1'b0);
    // R4: veto sticky even when 0,1,0 follows
    seq(16'b1010, 4, "R4");
    check("R4 sticky", 1'b0);
    seq(16'b0101_0010, 8, "R4");

    // R7: reset revives detection
    do_reset();
    check("R1 after trap", 1'b0);
    seq(16'b010, 3, "R7");
    check("R7 revived", 1'b1);

    // R8: long runs
    do_reset();
    seq(16'b00010, 5, "R8");
    check("R8 zeros", 1'b1);
    do_reset();
    seq(16'b111010, 6, "R8");
    check("R8 ones", 1'b1);

    // R9: 1,0,1 is not a veto
    do_reset();
    seq(16'b1010, 4, "R9");
    check("R9", 1'b1);

    // R4: plain 1,0,0 then patterns
    do_reset();
    seq(16'b100, 3, "R4");
    seq(16'b010, 3, "R4");
    check("R4 after 100", 1'b0);

    // Random stream with occasional resets
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 24) == 0) do_reset();
      else step(logic'($urandom % 2), "R2/R4 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule